// File: doc/BRIEF.md
# DMA Request Channel Multiplexer

This block sits between a set of peripheral DMA request lines and the request inputs of a DMA engine. Each of the sixteen DMA channels owns an 8-bit configuration register on a small byte-wide register bus. The register picks one of up to 64 source slots, switches the channel on or off, and selects between two modes. In plain routing the chosen request goes straight to the channel. In trigger-gated routing a rising edge on the channel's own periodic trigger input must arm the channel before the request can pass.

The highest-numbered slots are permanent request slots: their request reads as asserted whatever the input pin carries, so a channel routed to one of them requests continuously. In trigger-gated mode this gives a timer-paced transfer. A done pulse from the DMA engine retires the arm, so each trigger admits one service. Software is expected to turn a channel off before it retargets it. Routing one slot to two channels at once is not resolved by the block.

Top module: `dma_req_router`

## Requirements
- R1: Sixteen 8-bit configuration registers sit at byte offsets 0 to 15. A write with `bus_we` high stores `bus_wdata` at the next clock edge. `bus_rdata` always shows the register at `bus_addr`.
- R2: Register layout: bits [5:0] are the source slot, bit 6 selects trigger-gated mode, and bit 7 is the channel enable.
- R3: Reset sets every register to 0x00 and drives every `ch_req` bit low.
- R4: A channel whose enable bit is 0 keeps its `ch_req` low, whatever the slot, the mode and the source inputs.
- R5: In plain routing (enable=1, mode=0), `ch_req[c]` equals the selected slot's request one clock later.
- R6: Slots 60 to 63 read as permanently asserted, whatever is on their `src_req` bits.
- R7: In trigger-gated mode, a cycle where `trig_in[c]` is 1 after being 0 in the previous cycle arms the channel. While the channel is armed the selected request passes. The output first rises two clocks after the trigger is sampled. An unarmed channel keeps `ch_req` low.
- R8: Any write to a channel's register clears its arm. So does leaving trigger-gated mode or clearing enable.
- R9: A `ch_done[c]` pulse clears the channel's arm. If a trigger rising edge lands in the same cycle, the trigger wins and the channel stays armed.
- R10: A trigger input held high does not re-arm the channel. Only a fresh 0-to-1 transition does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Contents of the addressed register |
| src_req | input | 64 | Source slot request lines |
| trig_in | input | 16 | Per-channel periodic trigger, synchronous |
| ch_done | input | 16 | Per-channel service-complete pulse from the DMA engine |
| ch_req | output | 16 | Registered per-channel request to the DMA engine |

## Verification
Every cycle, the assertions check four things. A disabled channel never raises its request, and an unarmed trigger-gated channel stays silent. A register write always leaves that channel disarmed, and reset leaves all outputs low. Only the bench scenarios can show the rest: correct slot selection across all channel and slot pairs, the always-asserted top slots, the two-cycle arming latency, and that a held trigger does not re-arm. They also show the priority of a trigger edge over a coincident done pulse.

// File: rtl/drr_pkg.sv
package drr_pkg;

    localparam int CFG_W  = 8;
    localparam int SLOT_W = 6;

    typedef struct packed {
        logic              en;
        logic              gated;
        logic [SLOT_W-1:0] slot;
    } chan_cfg_t;

    localparam chan_cfg_t CFG_RESET = '{en: 1'b0, gated: 1'b0, slot: '0};

    // Request a channel should raise, given its config, arm state and slot hit.
    function automatic logic chan_active(chan_cfg_t cfg, logic armed, logic hit);
        return cfg.en && hit && (!cfg.gated || armed);
    endfunction

endpackage

// File: rtl/drr_cfg_bank.sv
module drr_cfg_bank
    import drr_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int ADDR_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CFG_W-1:0]  wdata,
    output logic [CFG_W-1:0]  rdata,
    output chan_cfg_t         cfg   [NUM_CH],
    output logic [NUM_CH-1:0] wr_hit
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_reg
        assign wr_hit[c] = we && (int'(addr) == c);

        always_ff @(posedge clk) begin
            if (rst)
                cfg[c] <= CFG_RESET;
            else if (wr_hit[c])
                cfg[c] <= chan_cfg_t'(wdata);
        end
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++)
            if (int'(addr) == c) rdata = CFG_W'(cfg[c]);
    end

endmodule

// File: rtl/drr_trig_arm.sv
module drr_trig_arm (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic gated,
    input  logic cfg_wr,
    input  logic trig,
    input  logic done,
    output logic armed
);

    logic trig_q;
    logic rise;

    assign rise = trig && !trig_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= 1'b0;
            armed  <= 1'b0;
        end else begin
            trig_q <= trig;
            if (cfg_wr || !(enable && gated))
                armed <= 1'b0;
            else if (rise)
                armed <= 1'b1;
            else if (done)
                armed <= 1'b0;
        end
    end

endmodule

// File: rtl/drr_chan_out.sv
module drr_chan_out
    import drr_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  chan_cfg_t          cfg,
    input  logic [NUM_SRC-1:0] src_vec,
    input  logic               armed,
    output logic               req
);

    logic hit;

    always_comb begin
        hit = 1'b0;
        for (int s = 0; s < NUM_SRC; s++)
            if (int'(cfg.slot) == s) hit = src_vec[s];
    end

    always_ff @(posedge clk) begin
        if (rst)
            req <= 1'b0;
        else
            req <= chan_active(cfg, armed, hit);
    end

endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
    import drr_pkg::*;
#(
    parameter int NUM_CH      = 16,
    parameter int NUM_SRC     = 64,
    parameter int ALWAYS_BASE = 60,
    localparam int ADDR_W = $clog2(NUM_CH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [CFG_W-1:0]   bus_wdata,
    output logic [CFG_W-1:0]   bus_rdata,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [NUM_CH-1:0]  trig_in,
    input  logic [NUM_CH-1:0]  ch_done,
    output logic [NUM_CH-1:0]  ch_req
);

    chan_cfg_t          cfg_q [NUM_CH];
    logic [NUM_CH-1:0]  wr_hit;
    logic [NUM_CH-1:0]  arm_v;
    logic [NUM_CH-1:0]  en_v;
    logic [NUM_CH-1:0]  mode_v;
    logic [NUM_SRC-1:0] src_vec;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        if (s >= ALWAYS_BASE) begin : g_on
            assign src_vec[s] = 1'b1;
        end else begin : g_pin
            assign src_vec[s] = src_req[s];
        end
    end

    drr_cfg_bank #(.NUM_CH(NUM_CH)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .cfg    (cfg_q),
        .wr_hit (wr_hit)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign en_v[c]   = cfg_q[c].en;
        assign mode_v[c] = cfg_q[c].gated;

        drr_trig_arm u_arm (
            .clk    (clk),
            .rst    (rst),
            .enable (cfg_q[c].en),
            .gated  (cfg_q[c].gated),
            .cfg_wr (wr_hit[c]),
            .trig   (trig_in[c]),
            .done   (ch_done[c]),
            .armed  (arm_v[c])
        );

        drr_chan_out #(.NUM_SRC(NUM_SRC)) u_out (
            .clk     (clk),
            .rst     (rst),
            .cfg     (cfg_q[c]),
            .src_vec (src_vec),
            .armed   (arm_v[c]),
            .req     (ch_req[c])
        );
    end

endmodule

// File: rtl/drr_checker.sv
module drr_checker #(
    parameter int NUM_CH = 16,
    localparam int ADDR_W = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] ch_req,
    input logic [NUM_CH-1:0] en_v,
    input logic [NUM_CH-1:0] mode_v,
    input logic [NUM_CH-1:0] arm_v,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr
);

    p_reset_quiet_r3: assert property (@(posedge clk)
        $past(rst) |-> (ch_req == '0 && en_v == '0));

    p_off_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (ch_req & ~$past(en_v)) == '0);

    p_unarmed_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (ch_req & $past(en_v & mode_v & ~arm_v)) == '0);

    p_write_disarm_r8: assert property (@(posedge clk) disable iff (rst)
        bus_we |=> !arm_v[$past(bus_addr)]);

    p_arm_needs_mode_r8: assert property (@(posedge clk) disable iff (rst)
        (arm_v & ~(en_v & mode_v)) == '0 || $past(bus_we));

endmodule

bind dma_req_router drr_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ch_req   (ch_req),
    .en_v     (en_v),
    .mode_v   (mode_v),
    .arm_v    (arm_v),
    .bus_we   (bus_we),
    .bus_addr (bus_addr)
);

// File: tb/dma_req_router_bench.sv
module dma_req_router_bench;

    localparam int NCH  = 16;
    localparam int NSRC = 64;
    localparam int BASE = 60;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_we = 1'b0;
    logic [3:0]      bus_addr = '0;
    logic [7:0]      bus_wdata = '0;
    logic [7:0]      bus_rdata;
    logic [NSRC-1:0] src_req = '0;
    logic [NCH-1:0]  trig_in = '0;
    logic [NCH-1:0]  ch_done = '0;
    logic [NCH-1:0]  ch_req;

    int  n_vec  = 0;
    int  n_bad  = 0;
    bit  closed = 0;

    always #4 clk = ~clk;   // 125 MHz

    dma_req_router u_dma_req_router (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_req(src_req),
        .trig_in(trig_in), .ch_done(ch_done), .ch_req(ch_req)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Write happens at the next rising edge; returns at the following falling edge.
    task automatic wr(int a, logic [7:0] v);
        bus_addr  = 4'(a);
        bus_wdata = v;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    function automatic logic [7:0] cfgv(bit en, bit gated, int slot);
        return {en, gated, 6'(slot)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!closed) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            closed = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R3 output in reset", 32'(ch_req), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        for (int a = 0; a < NCH; a++) begin
            bus_addr = 4'(a);
            #1;
            chk("R3 register reset value", 32'(bus_rdata), 32'h0);
        end
        chk("R3 output after reset", 32'(ch_req), 32'h0);

        // R1 readback: distinct pattern per register, none enabled (bit7 clear)
        for (int a = 0; a < NCH; a++) wr(a, 8'((a * 37 + 5) & 8'h7f));
        for (int a = 0; a < NCH; a++) begin
            bus_addr = 4'(a);
            #1;
            chk("R1 readback", 32'(bus_rdata), 32'((a * 37 + 5) & 8'h7f));
        end
        // R4: all disabled, every source asserted
        src_req = '1;
        trig_in = '1;
        @(negedge clk);
        @(negedge clk);
        chk("R4 disabled channels quiet", 32'(ch_req), 32'h0);
        trig_in = '0;
        for (int a = 0; a < NCH; a++) wr(a, 8'h00);

        // R2/R5/R6 sweep: every channel against every slot, plain routing
        for (int c = 0; c < NCH; c++) begin
            for (int s = 0; s < NSRC; s++) begin
                wr(c, cfgv(1, 0, s));
                src_req = '0;
                src_req[s] = 1'b1;
                @(negedge clk);
                chk("R5 selected slot routed", 32'(ch_req), 32'(1 << c));
                src_req = '0;
                @(negedge clk);
                chk(s >= BASE ? "R6 permanent slot" : "R5 slot deasserted",
                    32'(ch_req), s >= BASE ? 32'(1 << c) : 32'h0);
            end
            src_req = '1;
            wr(c, cfgv(0, 0, 3));
            @(negedge clk);
            chk("R4 cleared enable silences", 32'(ch_req), 32'h0);
            src_req = '0;
        end

        // R7..R10 on channel 5, slot 7
        src_req[7] = 1'b1;
        wr(5, cfgv(1, 1, 7));
        @(negedge clk);
        @(negedge clk);
        chk("R7 unarmed stays low", 32'(ch_req), 32'h0);
        trig_in[5] = 1'b1;
        @(negedge clk);
        chk("R7 one cycle after trigger", 32'(ch_req), 32'h0);
        @(negedge clk);
        chk("R7 armed passes request", 32'(ch_req), 32'(1 << 5));
        ch_done[5] = 1'b1;
        @(negedge clk);
        ch_done[5] = 1'b0;
        chk("R9 output before disarm visible", 32'(ch_req), 32'(1 << 5));
        @(negedge clk);
        chk("R9 done clears arm", 32'(ch_req), 32'h0);
        repeat (3) @(negedge clk);
        chk("R10 held trigger no rearm", 32'(ch_req), 32'h0);
        trig_in[5] = 1'b0;
        @(negedge clk);
        trig_in[5] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R10 fresh edge rearms", 32'(ch_req), 32'(1 << 5));
        trig_in[5] = 1'b0;
        @(negedge clk);
        trig_in[5] = 1'b1;
        ch_done[5] = 1'b1;
        @(negedge clk);
        ch_done[5] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R9 trigger beats done", 32'(ch_req), 32'(1 << 5));
        wr(5, cfgv(1, 1, 7));
        @(negedge clk);
        chk("R8 write clears arm", 32'(ch_req), 32'h0);
        trig_in[5] = 1'b0;
        @(negedge clk);
        trig_in[5] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R7 rearmed after write", 32'(ch_req), 32'(1 << 5));
        src_req[7] = 1'b0;
        @(negedge clk);
        chk("R7 armed but source idle", 32'(ch_req), 32'h0);
        src_req[7] = 1'b1;
        wr(5, cfgv(1, 0, 7));
        wr(5, cfgv(1, 1, 7));
        @(negedge clk);
        chk("R8 mode change leaves disarmed", 32'(ch_req), 32'h0);

        // R7 permanent slot on channel 15 paced by trigger
        wr(15, cfgv(1, 1, 62));
        trig_in[15] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R7 trigger paces permanent slot", 32'(ch_req), 32'(1 << 15));

        closed = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule